// File: doc/BRIEF.md
# Fractional Clock Divider

This block turns a fast source clock into a slower rate whose average period is N + b/a source cycles. It does so by mixing short periods of N cycles with long periods of N+1 cycles. A frame is a run of a output periods. Each frame holds exactly b long periods and a-b short ones, spread as evenly as the ratio allows.

When the fraction is at or below one half, the short periods come in runs and each run is closed by a single long one. Above one half, the long periods come in runs and each run is opened by a single short one. An accumulator makes the choice: it adds b at the start of every period, and when the sum reaches a it takes a away and makes that period long.

The block drives two outputs. The first is a one-cycle tick in the last cycle of each period, used as a clock enable. The second is an optional square clock that is high for the first half of each period. New settings are taken only at a frame boundary, so a frame in flight always keeps its b-in-a count.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held, and in the cycle right after it is released, both `tick` and `clk_out` are low. On the first rising clock edge with `rst_n` high, the block loads the settings and starts the first period. After that edge the period counter stands at 0.
- R2: Every output period lasts either N or N+1 source cycles. `tick` is high for exactly the last cycle of each period, so it is never high in two consecutive cycles.
- R3: Every frame of a periods lasts exactly a*N + b source cycles, which means it holds exactly b long periods.
- R4: Take period k of a frame, with k counted from 1. It is long exactly when floor(k*b/a) is greater than floor((k-1)*b/a). For b at most a/2 this gives runs of short periods, each run ended by one long period.
- R5: For b above a/2, the same rule gives runs of long periods, each run begun by one short period. Two short periods never occur back to back inside a frame.
- R6: When b is 0, or when b is not less than a, every period is exactly N cycles long, as in a plain integer divider.
- R7: A `div_int` value of 0 or 1 is used as 2. A `frac_den` value of 0 is used as 1.
- R8: A change on `div_int`, `frac_num` or `frac_den` has no effect until the frame in progress ends. The settings present on the clock edge that closes a frame govern the whole of the next frame.
- R9: With `GEN_CLK` set to 1, `clk_out` is high for the first ceil(L/2) cycles of a period of L cycles and low for the rest. With `GEN_CLK` set to 0, `clk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int | input | 8 | Integer part N of the ratio |
| frac_num | input | FRAC_W | Fraction numerator b |
| frac_den | input | FRAC_W | Fraction denominator a |
| tick | output | 1 | One-cycle pulse in the last cycle of each period |
| clk_out | output | 1 | Divided clock, high for the first half of each period |

## Verification
The delicate collision is a settings change that arrives in the same cycle as the end of a frame. On that edge the block must reload its settings and also pick the length of the next period, and it must use the new values for both. The bench provokes this by waiting until its reference model shows the final tick of a frame, then changing all three inputs in that very cycle. A second change is made in the middle of a frame, and for that one every later period must still follow the old settings until the frame closes. The bench judges both cases cycle by cycle against a model that builds each frame's list of period lengths from the floor formula. It also measures one full frame from the outputs alone, from the first tick to the last, and checks its total length.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int FRAC_W  = 6,
  parameter bit GEN_CLK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        div_int,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  output logic              tick,
  output logic              clk_out
);
  localparam int CW = 9;
  localparam int AW = FRAC_W + 1;

  logic              primed, is_long, tick_q, clk_q;
  logic [7:0]        n_cur;
  logic [FRAC_W-1:0] b_cur, a_cur, acc, pcnt;
  logic [CW-1:0]     cnt;

  wire [7:0]        n_in = (div_int < 8'd2) ? 8'd2 : div_int;
  wire [FRAC_W-1:0] a_in = (frac_den == '0) ? FRAC_W'(1) : frac_den;
  wire [FRAC_W-1:0] b_in = (frac_num >= a_in) ? '0 : frac_num;

  wire [CW-1:0] len       = {1'b0, n_cur} + CW'(is_long);
  wire          at_end    = primed && (cnt == len - CW'(1));
  wire          frame_end = at_end && (pcnt == a_cur - FRAC_W'(1));
  wire          reload    = !primed || frame_end;
  wire          step      = !primed || at_end;

  wire [7:0]        n_sel    = reload ? n_in : n_cur;
  wire [FRAC_W-1:0] b_sel    = reload ? b_in : b_cur;
  wire [FRAC_W-1:0] a_sel    = reload ? a_in : a_cur;
  wire [FRAC_W-1:0] acc_base = reload ? '0 : acc;

  wire [AW-1:0] sum     = {1'b0, acc_base} + {1'b0, b_sel};
  wire          long_n  = sum >= {1'b0, a_sel};
  wire [AW-1:0] acc_new = long_n ? sum - {1'b0, a_sel} : sum;

  wire [CW-1:0] cnt_nx  = step ? '0 : cnt + CW'(1);
  wire [CW-1:0] len_nx  = step ? ({1'b0, n_sel} + CW'(long_n)) : len;
  wire [CW-1:0] half_nx = (len_nx + CW'(1)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      is_long <= 1'b0;
      n_cur   <= '0;
      b_cur   <= '0;
      a_cur   <= '0;
      acc     <= '0;
      pcnt    <= '0;
      cnt     <= '0;
      tick_q  <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      primed <= 1'b1;
      cnt    <= cnt_nx;
      tick_q <= (cnt_nx == len_nx - CW'(1));
      clk_q  <= (cnt_nx < half_nx);
      if (step) begin
        is_long <= long_n;
        acc     <= acc_new[FRAC_W-1:0];
        pcnt    <= reload ? '0 : pcnt + FRAC_W'(1);
      end
      if (reload) begin
        n_cur <= n_in;
        b_cur <= b_in;
        a_cur <= a_in;
      end
    end
  end

  assign tick = tick_q;

  generate
    if (GEN_CLK) begin : g_clk
      assign clk_out = clk_q;
    end else begin : g_noclk
      assign clk_out = 1'b0;
    end
  endgenerate

  // R2
  tick_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (cnt < len));

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (acc < a_cur));

  // R3
  frame_balanced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && primed && pcnt == a_cur - FRAC_W'(1)) |-> (acc == '0));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !(tick && pcnt == a_cur - FRAC_W'(1)))
      |=> ($stable(n_cur) && $stable(b_cur) && $stable(a_cur)));

  // R9
  clk_low_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !clk_out);
endmodule

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    div_int = 8'd4;
  logic [FW-1:0] frac_num = '0;
  logic [FW-1:0] frac_den = FW'(1);
  logic          tick, clk_out, tick1, clk_out1;

  always #2 clk = ~clk;

  frac_clk_div #(.FRAC_W(FW), .GEN_CLK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .frac_num(frac_num),
    .frac_den(frac_den), .tick(tick), .clk_out(clk_out));

  frac_clk_div #(.FRAC_W(FW), .GEN_CLK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .frac_num(frac_num),
    .frac_den(frac_den), .tick(tick1), .clk_out(clk_out1));

  int tests = 0, fails = 0, cycles = 0;
  string req = "R1";

  int q[$];
  int pos = 0, curlen = 0;
  bit mp = 1'b0;

  task automatic build_frame();
    int n, a, b;
    n = (div_int < 2) ? 2 : int'(div_int);
    a = (frac_den == 0) ? 1 : int'(frac_den);
    b = (int'(frac_num) >= a) ? 0 : int'(frac_num);
    for (int k = 1; k <= a; k++)
      q.push_back(n + (((k * b) / a) > (((k - 1) * b) / a) ? 1 : 0));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = 1'b0; q.delete(); pos = 0; curlen = 0;
    end else if (!mp) begin
      mp = 1'b1; build_frame(); curlen = q.pop_front(); pos = 0;
    end else if (pos == curlen - 1) begin
      pos = 0;
      if (q.size() == 0) build_frame();
      curlen = q.pop_front();
    end else begin
      pos++;
    end
  end

  task automatic check(string r, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", r, what, act, exp, cycles);
    end
  endtask

  bit meas_req = 0, meas_on = 0;
  int ma = 0, mn = 0, mb = 0, mcyc = 0, mtk = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(req, "tick", int'(tick), int'(mp && pos == curlen - 1));
      check("R9", "clk_out", int'(clk_out), int'(mp && pos < (curlen + 1) / 2));
      check("R9", "clk_out disabled", int'(clk_out1), 0);
      check(req, "tick of second instance", int'(tick1), int'(mp && pos == curlen - 1));
    end
    if (meas_req && mp && pos == 0 && q.size() == ma - 1) begin
      meas_req = 0; meas_on = 1; mcyc = 0; mtk = 0;
    end
    if (meas_on) begin
      mcyc++;
      if (tick) begin
        mtk++;
        if (mtk == ma) begin
          check("R3", "frame length", mcyc, ma * mn + mb);
          meas_on = 0;
        end
      end
    end
  end

  task automatic cfg(int n, int b, int a);
    @(negedge clk);
    div_int = 8'(n); frac_num = FW'(b); frac_den = FW'(a);
  endtask

  task automatic run(int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check("R1", "tick in reset", int'(tick), 0);
    check("R1", "clk_out in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    run(20);
    req = "R6"; cfg(5, 0, 3); run(60);
    req = "R4"; cfg(5, 1, 4); run(150);
    req = "R4"; cfg(3, 2, 7); run(200);
    req = "R5"; cfg(3, 5, 7); run(200);
    req = "R5"; cfg(4, 11, 12); run(250);
    req = "R7"; cfg(0, 3, 0); run(40);
    req = "R7"; cfg(1, 1, 3); run(60);
    req = "R6"; cfg(6, 9, 4); run(100);
    req = "R3"; cfg(6, 3, 8); run(80);
    ma = 8; mn = 6; mb = 3; meas_req = 1;
    run(200);
    check("R3", "frame measured", int'(meas_req || meas_on), 0);
    req = "R8"; cfg(7, 5, 13); run(40);
    cfg(2, 1, 2); run(30);
    cfg(9, 4, 9); run(200);
    req = "R8";
    do @(negedge clk); while (!(mp && pos == curlen - 1 && q.size() == 0));
    div_int = 8'd3; frac_num = FW'(2); frac_den = FW'(5);
    run(150);
    do @(negedge clk); while (!(mp && pos == curlen - 1 && q.size() == 0));
    div_int = 8'd2; frac_num = FW'(1); frac_den = FW'(2);
    run(60);
    req = "R2"; cfg(255, 63, 63); run(400);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule